// File: doc/BRIEF.md
# Wake-Pin Interrupt Controller

This block watches a small group of asynchronous wake pins and turns selected activity on them into interrupt events. Every pin has its own configuration word that picks a trigger condition: a held level, a single edge direction, any change, or nothing at all. Events land in a sticky pending register. Software acknowledges them by writing ones to a clear location. An enable mask qualifies the pending bits, and any surviving bit drives a single shared interrupt line.

A routing word gates which sources go on to the rest of the chip. One field passes each qualified pin event to its own output. A second field passes three peripheral interrupt lines (real-time clock, infrared, watchdog). Two further fields choose which pins and which peripherals may raise a wake request toward a power manager. All state is reached over a simple 32-bit read/write bus with single-cycle writes and registered reads.

Top module: `wake_irq_ctrl`

## Requirements
- R1: After reset, the pending, mask and routing registers read 0, and each pin's config word reads 0x8: trigger code 4 in bits 3:1, reset bit 0, and bit 0 equal to the pin level.
- R2: Trigger codes in config bits 3:1 behave as follows. Code 0 fires while the pin is low and code 1 while it is high. Code 2 fires on a high-to-low change, code 3 on a low-to-high change and code 6 on any change. Codes 4, 5 and 7 never fire.
- R3: Pending register 0x310 bit n latches an event on pin n. Writing 1 to bit n of clear location 0x318 drops it. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: `wake_irq_o` is high one cycle after the AND of pending and mask register 0x314 is nonzero, and low one cycle after it is zero.
- R5: In level codes the pending bit is set again every cycle while the level holds, so a clear only sticks once the pin has left the trigger level.
- R6: Writing a config word with bit 4 set drops that pin's pending bit and discards any event flagged in that cycle. Bit 4 always reads back as 0.
- R7: Routing register 0x31C reads back only its defined bits. `periph_irq_o[k]` equals peripheral input k ANDed with route bit k (bits 0..2). `pin_irq_o[n]` equals pending AND mask AND route bit 8+n. Both outputs are registered with one cycle of delay.
- R8: `wake_req_o` is high one cycle after any pending bit n has route bit 24+n set, or any peripheral input k is high with route bit 16+k set.
- R9: The config word of pin n sits at 0x330 + 8*n. Its bit 0 reads the pin level after a two-stage synchroniser, and its bits 3:1 read back the stored trigger code.
- R10: Setting up in the order mask to 0, then routing, then every pin to code 4, never raises `wake_irq_o`. Once pending is cleared, later pin activity leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_pin_i | input | NUM_PINS | Asynchronous wake pins |
| periph_irq_i | input | NUM_PERIPH | Peripheral interrupts: clock, infrared, watchdog |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read strobe |
| wake_irq_o | output | 1 | Shared pin interrupt |
| pin_irq_o | output | NUM_PINS | Routed per-pin interrupts |
| periph_irq_o | output | NUM_PERIPH | Routed peripheral interrupts |
| wake_req_o | output | 1 | Wake request |

## Verification
The assertions assume that the peripheral lines and bus signals are synchronous to `clk`. They also assume that a strobe lasts exactly one cycle. Only the wake pins may change at arbitrary times. The stimulus drives every input at the falling edge and holds bus strobes for a single cycle. It changes pins only at falling edges and then allows the two synchroniser stages to settle before it samples results. The one exception is the collision case, where a clear write is placed on the exact cycle in which a rising-edge event reaches the pending register.

// File: rtl/wake_irq_pkg.sv
`timescale 1ns/1ps
package wake_irq_pkg;
  localparam int REG_W = 32;
  localparam int OFF_STATUS   = 'h310;
  localparam int OFF_ENABLE   = 'h314;
  localparam int OFF_CLEAR    = 'h318;
  localparam int OFF_ROUTE    = 'h31C;
  localparam int OFF_CFG_BASE = 'h330;
  localparam int CFG_STRIDE   = 8;
  localparam int CFG_LVL_BIT  = 0;
  localparam int CFG_MODE_LSB = 1;
  localparam int CFG_RST_BIT  = 4;
  localparam int PER_PASS_LSB = 0;
  localparam int PIN_PASS_LSB = 8;
  localparam int PER_WAKE_LSB = 16;
  localparam int PIN_WAKE_LSB = 24;
  localparam logic [2:0] TRIG_LVL_LO = 3'd0;
  localparam logic [2:0] TRIG_LVL_HI = 3'd1;
  localparam logic [2:0] TRIG_FALL   = 3'd2;
  localparam logic [2:0] TRIG_RISE   = 3'd3;
  localparam logic [2:0] TRIG_NONE   = 3'd4;
  localparam logic [2:0] TRIG_ANY    = 3'd6;
endpackage

// File: rtl/wake_pin_unit.sv
`timescale 1ns/1ps
module wake_pin_unit
  import wake_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_async_i,
  input  logic       cfg_we_i,
  input  logic [2:0] cfg_mode_i,
  input  logic       cfg_clr_hist_i,
  output logic       level_o,
  output logic [2:0] mode_o,
  output logic       evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [2:0]             mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      mode_q <= TRIG_NONE;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (cfg_we_i) mode_q <= cfg_mode_i;
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];
  assign mode_o  = mode_q;

  always_comb begin
    case (mode_q)
      TRIG_LVL_LO: evt_o = ~level_o;
      TRIG_LVL_HI: evt_o = level_o;
      TRIG_FALL:   evt_o = prev_q & ~level_o;
      TRIG_RISE:   evt_o = ~prev_q & level_o;
      TRIG_ANY:    evt_o = prev_q ^ level_o;
      default:     evt_o = 1'b0;
    endcase
  end

  // R2: edge events agree with the previous synchronised sample
  assert_rise_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TRIG_RISE && evt_o) |-> (level_o && !$past(level_o)));
  assert_fall_edge_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TRIG_FALL && evt_o) |-> (!level_o && $past(level_o)));
  // R2: codes without a trigger stay silent whatever the pin does
  assert_silent_code_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TRIG_NONE || mode_q == 3'd5 || mode_q == 3'd7) |-> !evt_o);
endmodule

// File: rtl/wake_route_out.sv
`timescale 1ns/1ps
module wake_route_out #(
  parameter int NUM_PINS   = 4,
  parameter int NUM_PERIPH = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   status_i,
  input  logic [NUM_PINS-1:0]   enable_i,
  input  logic [NUM_PINS-1:0]   pin_pass_i,
  input  logic [NUM_PINS-1:0]   pin_wake_i,
  input  logic [NUM_PERIPH-1:0] per_pass_i,
  input  logic [NUM_PERIPH-1:0] per_wake_i,
  input  logic [NUM_PERIPH-1:0] periph_irq_i,
  output logic                  wake_irq_o,
  output logic [NUM_PINS-1:0]   pin_irq_o,
  output logic [NUM_PERIPH-1:0] periph_irq_o,
  output logic                  wake_req_o
);
  logic [NUM_PINS-1:0] live;
  assign live = status_i & enable_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_irq_o   <= 1'b0;
      pin_irq_o    <= '0;
      periph_irq_o <= '0;
      wake_req_o   <= 1'b0;
    end else begin
      wake_irq_o   <= |live;
      pin_irq_o    <= live & pin_pass_i;
      periph_irq_o <= periph_irq_i & per_pass_i;
      wake_req_o   <= (|(status_i & pin_wake_i)) | (|(periph_irq_i & per_wake_i));
    end
  end

  // R4: a rising shared interrupt needs a qualified pending bit the cycle before
  assert_irq_source_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_irq_o) |-> $past(|(status_i & enable_i)));
  // R7: no peripheral passes whose route bit was clear
  assert_periph_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !(|(periph_irq_o & ~$past(per_pass_i))));
  // R8: a wake request always has a routed source behind it
  assert_wake_source_R8: assert property (@(posedge clk) disable iff (rst)
    wake_req_o |-> $past((|pin_wake_i) || (|per_wake_i)));
endmodule

// File: rtl/wake_irq_ctrl.sv
`timescale 1ns/1ps
module wake_irq_ctrl
  import wake_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int NUM_PERIPH  = 3,
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   wake_pin_i,
  input  logic [NUM_PERIPH-1:0] periph_irq_i,
  input  logic                  bus_sel_i,
  input  logic                  bus_wr_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [REG_W-1:0]      bus_wdata_i,
  output logic [REG_W-1:0]      bus_rdata_o,
  output logic                  wake_irq_o,
  output logic [NUM_PINS-1:0]   pin_irq_o,
  output logic [NUM_PERIPH-1:0] periph_irq_o,
  output logic                  wake_req_o
);
  localparam int MODE_W = 3;

  logic wr_en, rd_en, hit_en, hit_clr, hit_route;
  logic [NUM_PINS-1:0]   status_q, enable_q, pin_pass_q, pin_wake_q;
  logic [NUM_PINS-1:0]   pin_evt, pin_lvl, cfg_we, cfg_rst;
  logic [NUM_PERIPH-1:0] per_pass_q, per_wake_q;
  logic [MODE_W-1:0]     pin_mode [NUM_PINS];
  logic [REG_W-1:0]      rd_word;
  logic                  unused_wdata;

  assign wr_en     = bus_sel_i & bus_wr_i;
  assign rd_en     = bus_sel_i & ~bus_wr_i;
  assign hit_en    = wr_en && (bus_addr_i == ADDR_W'(OFF_ENABLE));
  assign hit_clr   = wr_en && (bus_addr_i == ADDR_W'(OFF_CLEAR));
  assign hit_route = wr_en && (bus_addr_i == ADDR_W'(OFF_ROUTE));
  assign unused_wdata = ^bus_wdata_i;

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    assign cfg_we[n]  = wr_en && (bus_addr_i == ADDR_W'(OFF_CFG_BASE + n * CFG_STRIDE));
    assign cfg_rst[n] = cfg_we[n] & bus_wdata_i[CFG_RST_BIT];

    wake_pin_unit #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk            (clk),
      .rst            (rst),
      .pin_async_i    (wake_pin_i[n]),
      .cfg_we_i       (cfg_we[n]),
      .cfg_mode_i     (bus_wdata_i[CFG_MODE_LSB +: MODE_W]),
      .cfg_clr_hist_i (cfg_rst[n]),
      .level_o        (pin_lvl[n]),
      .mode_o         (pin_mode[n]),
      .evt_o          (pin_evt[n])
    );

    // R3: an event is never lost, even against a clear write
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
      (pin_evt[n] && !cfg_rst[n]) |=> status_q[n]);
    // R3: a clear with no competing event drops the bit
    assert_clear_drops_R3: assert property (@(posedge clk) disable iff (rst)
      (hit_clr && bus_wdata_i[n] && !pin_evt[n] && !cfg_rst[n]) |=> !status_q[n]);
    // R6: the config reset bit empties the pending bit
    assert_cfg_reset_R6: assert property (@(posedge clk) disable iff (rst)
      cfg_rst[n] |=> !status_q[n]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q   <= '0;
      pin_pass_q <= '0;
      pin_wake_q <= '0;
      per_pass_q <= '0;
      per_wake_q <= '0;
    end else begin
      if (hit_en) enable_q <= bus_wdata_i[NUM_PINS-1:0];
      if (hit_route) begin
        per_pass_q <= bus_wdata_i[PER_PASS_LSB +: NUM_PERIPH];
        pin_pass_q <= bus_wdata_i[PIN_PASS_LSB +: NUM_PINS];
        per_wake_q <= bus_wdata_i[PER_WAKE_LSB +: NUM_PERIPH];
        pin_wake_q <= bus_wdata_i[PIN_WAKE_LSB +: NUM_PINS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
    end else begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (cfg_rst[n])                    status_q[n] <= 1'b0;
        else if (pin_evt[n])               status_q[n] <= 1'b1;
        else if (hit_clr && bus_wdata_i[n]) status_q[n] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    if (bus_addr_i == ADDR_W'(OFF_STATUS)) rd_word[NUM_PINS-1:0] = status_q;
    if (bus_addr_i == ADDR_W'(OFF_ENABLE)) rd_word[NUM_PINS-1:0] = enable_q;
    if (bus_addr_i == ADDR_W'(OFF_ROUTE)) begin
      rd_word[PER_PASS_LSB +: NUM_PERIPH] = per_pass_q;
      rd_word[PIN_PASS_LSB +: NUM_PINS]   = pin_pass_q;
      rd_word[PER_WAKE_LSB +: NUM_PERIPH] = per_wake_q;
      rd_word[PIN_WAKE_LSB +: NUM_PINS]   = pin_wake_q;
    end
    for (int n = 0; n < NUM_PINS; n++) begin
      if (bus_addr_i == ADDR_W'(OFF_CFG_BASE + n * CFG_STRIDE)) begin
        rd_word[CFG_MODE_LSB +: MODE_W] = pin_mode[n];
        rd_word[CFG_LVL_BIT]            = pin_lvl[n];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata_o <= '0;
    else if (rd_en) bus_rdata_o <= rd_word;
  end

  wake_route_out #(.NUM_PINS(NUM_PINS), .NUM_PERIPH(NUM_PERIPH)) u_out (
    .clk          (clk),
    .rst          (rst),
    .status_i     (status_q),
    .enable_i     (enable_q),
    .pin_pass_i   (pin_pass_q),
    .pin_wake_i   (pin_wake_q),
    .per_pass_i   (per_pass_q),
    .per_wake_i   (per_wake_q),
    .periph_irq_i (periph_irq_i),
    .wake_irq_o   (wake_irq_o),
    .pin_irq_o    (pin_irq_o),
    .periph_irq_o (periph_irq_o),
    .wake_req_o   (wake_req_o)
  );
endmodule

// File: tb/wake_irq_ctrl_bench.sv
`timescale 1ns/1ps
module wake_irq_ctrl_bench;
  localparam int NP = 4;
  localparam int NK = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic [NK-1:0] per_in = '0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake_irq, wake_req;
  logic [NP-1:0] pin_irq;
  logic [NK-1:0] per_irq;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wake_irq_ctrl u_wake_irq_ctrl (
    .clk(clk), .rst(rst), .wake_pin_i(pins), .periph_irq_i(per_in),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .wake_irq_o(wake_irq), .pin_irq_o(pin_irq),
    .periph_irq_o(per_irq), .wake_req_o(wake_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = 12'(a); wdata = d;
    @(posedge clk);
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk); sel = 1; wr = 0; addr = 12'(a);
    @(posedge clk);
    @(negedge clk); sel = 0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic pre_exp(input int m, input logic a, input logic b);
    case (m)
      0: return !a || !b;
      1: return a || b;
      2: return a && !b;
      3: return !a && b;
      6: return a != b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic post_exp(input int m, input logic b);
    case (m)
      0: return !b;
      1: return b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int cfg_addr(input int n);
    return 'h330 + 8 * n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 0;
    idle(2);

    // R1: reset values
    bus_read('h310, d); check("R1 status", d, 0);
    bus_read('h314, d); check("R1 enable", d, 0);
    bus_read('h31C, d); check("R1 route", d, 0);
    for (int n = 0; n < NP; n++) begin
      bus_read(cfg_addr(n), d); check("R1 cfg", d, 32'h8);
    end
    check("R1 wake_irq", wake_irq, 0);

    // R2 R5 R6 R9: sweep every pin, every code, every pin transition
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 8; m++) begin
        for (int ab = 0; ab < 4; ab++) begin
          logic a, b;
          a = ab[1]; b = ab[0];
          @(negedge clk); pins[p] = a;
          idle(4);
          bus_write(cfg_addr(p), 32'(m << 1));
          @(negedge clk); pins[p] = b; sel = 1; wr = 1;
          addr = 12'(cfg_addr(p)); wdata = 32'((m << 1) | 16);
          @(posedge clk);
          @(negedge clk); sel = 0; wr = 0;
          idle(6);
          bus_read('h310, d);
          check("R2 R5 pending after transition", d, 32'(pre_exp(m, a, b)) << p);
          bus_write('h318, 32'(1) << p);
          idle(2);
          bus_read('h310, d);
          check("R5 pending after clear", d, 32'(post_exp(m, b)) << p);
          bus_read(cfg_addr(p), d);
          check("R9 R6 cfg readback", d, 32'((m << 1) | int'(b)));
          bus_write(cfg_addr(p), 32'h18);
        end
      end
      @(negedge clk); pins[p] = 0;
    end
    idle(4);

    // R3: rising event and clear write in the same cycle
    bus_write(cfg_addr(1), 32'(3 << 1));
    @(negedge clk); pins[1] = 1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); sel = 1; wr = 1; addr = 12'h318; wdata = 32'h2;
    @(posedge clk);
    @(negedge clk); sel = 0; wr = 0;
    bus_read('h310, d); check("R3 set beats clear", d, 32'h2);
    bus_write('h318, 32'h2);
    bus_read('h310, d); check("R3 clear drops bit", d, 0);

    // R6: reset bit drops a latched edge event
    bus_write(cfg_addr(2), 32'(3 << 1));
    @(negedge clk); pins[2] = 1;
    idle(5);
    bus_read('h310, d); check("R6 edge latched", d, 32'h4);
    bus_write(cfg_addr(2), 32'((3 << 1) | 16));
    idle(2);
    bus_read('h310, d); check("R6 reset bit clears", d, 0);
    bus_write(cfg_addr(1), 32'h8);
    bus_write(cfg_addr(2), 32'h8);
    @(negedge clk); pins = '0;
    idle(4);

    // R4 R7: mask and pin routing
    bus_write(cfg_addr(0), 32'(1 << 1));
    @(negedge clk); pins[0] = 1;
    idle(5);
    bus_write('h314, 32'h0); idle(1);
    check("R4 masked", wake_irq, 0);
    bus_write('h314, 32'h1); idle(1);
    check("R4 unmasked", wake_irq, 1);
    bus_write('h314, 32'h2); idle(1);
    check("R4 other mask bit", wake_irq, 0);
    bus_write('h314, 32'h1);
    bus_write('h31C, 32'h100); idle(1);
    check("R7 pin routed", pin_irq, 4'h1);
    bus_write('h31C, 32'h200); idle(1);
    check("R7 pin not routed", pin_irq, 4'h0);
    bus_write('h31C, 32'hFFFF_FFFF);
    bus_read('h31C, d); check("R7 route readback", d, 32'h0F07_0F07);

    // R7 R8: routing sweep of peripheral passthrough and wake sources
    for (int r = 0; r < 8; r++) begin
      for (int pi = 0; pi < 8; pi++) begin
        int w, pw;
        w = r ^ 5;
        pw = (r >> 1) & 1;
        bus_write('h31C, 32'(r | (w << 16) | (pw << 24)));
        @(negedge clk); per_in = 3'(pi);
        idle(1);
        check("R7 periph passthrough", 32'(per_irq), 32'(pi & r));
        check("R8 wake request", 32'(wake_req), 32'((pw != 0) || ((pi & w) != 0)));
      end
    end
    @(negedge clk); per_in = '0;

    // R10: setup order yields no spurious interrupt
    for (int n = 0; n < NP; n++) bus_write(cfg_addr(n), 32'(1 << 1));
    @(negedge clk); pins = '1;
    idle(5);
    bus_write('h314, 32'hF); idle(1);
    check("R10 precondition irq", wake_irq, 1);
    bus_write('h314, 32'h0); idle(1);
    check("R10 after mask", wake_irq, 0);
    bus_write('h31C, 32'h0F00); idle(1);
    check("R10 after route", wake_irq, 0);
    for (int n = 0; n < NP; n++) begin
      bus_write(cfg_addr(n), 32'h8);
      check("R10 during code setup", wake_irq, 0);
    end
    bus_write('h318, 32'hF);
    @(negedge clk); pins = 4'h5;
    idle(4);
    @(negedge clk); pins = 4'hA;
    idle(5);
    bus_read('h310, d); check("R10 pending stays clear", d, 0);
    check("R10 irq low", wake_irq, 0);
    check("R10 pin outputs low", pin_irq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule